// File: doc/BRIEF.md
# Chained Tile Configuration Loader

Every tile of a reconfigurable array sits on a shared 16-bit configuration chain. This block is the receiver in one tile. Words arrive on the chain input with a valid bit. Each word is passed unchanged to the chain output one cycle later, so the next tile sees the same stream. The receiver parses the stream as packets. A packet starts with a tile identifier, then a total length, then fixed sections for the 48-bit core register, the 80-bit routing register and the 16-bit output start value. Any words left after those sections are content words for the tile's register file or memory.

Only a tile whose own identifier equals the packet's first word loads anything. A tile that does not match still counts the words of the packet, so that it recognises the header of the next packet. The parser has six named states:

- `ST_HDR_ID` waits for the identifier word and records whether it matches.
- `ST_HDR_LEN` takes the length. A length of 2 or less leads back to `ST_HDR_ID`. Any other length leads to `ST_CORE`.
- `ST_CORE`, `ST_ROUTE` and `ST_INIT` each move to the next section after that section's word count.
- `ST_INIT` leads on to `ST_CONTENT`.

Every payload state returns to `ST_HDR_ID` on the final word of the packet.

Top module: `cfg_tile_loader`

## Requirements
- R1: Every word accepted while `cfg_in_vld` is high appears on `cfg_out` with `cfg_out_vld` high exactly one cycle later, whether or not the packet matches. A cycle with `cfg_in_vld` low gives `cfg_out_vld` low in the next cycle.
- R2: The first word of a packet is compared with `tile_id`. Only an equal value lets the packet change any register, write output or the loaded flag.
- R3: The second word is the total packet length in words, counting the identifier and length words. A length of 0, 1 or 2 ends the packet right after the length word.
- R4: The first three payload words of a matching packet shift into `core_cfg` most-significant first, so words a, b, c give {a,b,c}.
- R5: The next five payload words shift into `route_cfg` the same way. The first of them ends in bits 79:64.
- R6: The ninth payload word loads `init_val`.
- R7: Each payload word after the ninth in a matching packet produces, one cycle later, a one-cycle `mem_wr_en` pulse. The pulse carries that word on `mem_wr_data` and a content address on `mem_wr_addr`. The address counts from 0 in arrival order.
- R8: A non-matching tile skips exactly length minus 2 payload words and then treats the next word as a new identifier. Payload words that happen to look like a header never change its registers.
- R9: `cfg_loaded` rises one cycle after the final word of a matching packet and stays high until reset.
- R10: When the length ends a packet early, the payload words that did arrive still shift into their section. Later sections keep their values and no writes occur.
- R11: After reset, every register output and `cfg_loaded` is zero and `cfg_out_vld` is low.
- R12: Cycles with `cfg_in_vld` low between words do not advance the parser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_id | input | 16 | Identifier of this tile |
| cfg_in | input | 16 | Chain word in |
| cfg_in_vld | input | 1 | Chain word valid |
| cfg_out | output | 16 | Chain word forwarded to next tile |
| cfg_out_vld | output | 1 | Forwarded word valid |
| core_cfg | output | 48 | Core configuration register |
| route_cfg | output | 80 | Routing configuration register |
| init_val | output | 16 | Output start value |
| cfg_loaded | output | 1 | A matching packet has completed |
| mem_wr_en | output | 1 | Content write strobe |
| mem_wr_addr | output | 10 | Content write address |
| mem_wr_data | output | 16 | Content write data |

## Verification
The hardest case to reach from the ports is a tile that must skip a foreign packet whose payload contains its own identifier followed by a short length. If the word count slips by even one, the tile resynchronises on that fake header and raises the loaded flag. The stimulus sends such a foreign packet and follows it immediately with a genuine matching packet. It also sends a foreign packet of length 1, then a matching packet. Idle cycles are inserted between words, so the count must hold across gaps.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    typedef enum logic [2:0] {
        ST_HDR_ID,
        ST_HDR_LEN,
        ST_CORE,
        ST_ROUTE,
        ST_INIT,
        ST_CONTENT
    } cfg_state_e;
endpackage

// File: rtl/cfgld_fwd.sv
module cfgld_fwd #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         din_vld,
    output logic [W-1:0] dout,
    output logic         dout_vld
);
    logic [W-1:0] word_q;
    logic         vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= din_vld;
            if (din_vld) word_q <= din;
        end
    end

    assign dout     = word_q;
    assign dout_vld = vld_q;

    // R1: forwarded one cycle later, unchanged
    p_fwd_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> (dout_vld && dout == $past(din)));
    // R1: idle in gives idle out
    p_fwd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> !dout_vld);
endmodule

// File: rtl/cfgld_parser.sv
module cfgld_parser
    import cfgld_pkg::*;
#(
    parameter int W           = 16,
    parameter int CORE_WORDS  = 3,
    parameter int ROUTE_WORDS = 5,
    parameter int INIT_WORDS  = 1,
    parameter int ADDR_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      word,
    input  logic              word_vld,
    input  logic [W-1:0]      tile_id,
    output logic              ld_core,
    output logic              ld_route,
    output logic              ld_init,
    output logic              ld_cont,
    output logic              pkt_done,
    output logic [ADDR_W-1:0] cont_addr
);
    localparam int SEC_MAX_A = (CORE_WORDS > ROUTE_WORDS) ? CORE_WORDS : ROUTE_WORDS;
    localparam int SEC_MAX   = (SEC_MAX_A > INIT_WORDS) ? SEC_MAX_A : INIT_WORDS;
    localparam int SEC_W     = $clog2(SEC_MAX + 1);

    cfg_state_e        state_q, state_d;
    logic              match_q;
    logic [W-1:0]      rem_q;
    logic [SEC_W-1:0]  sec_q;
    logic [ADDR_W-1:0] addr_q;

    logic in_payload;
    logic last_word;
    logic hdr_short;

    assign in_payload = (state_q == ST_CORE) || (state_q == ST_ROUTE) ||
                        (state_q == ST_INIT) || (state_q == ST_CONTENT);
    assign last_word  = in_payload && (rem_q == W'(1));
    assign hdr_short  = (word <= W'(2));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR_ID:  state_d = ST_HDR_LEN;
            ST_HDR_LEN: state_d = hdr_short ? ST_HDR_ID : ST_CORE;
            ST_CORE: begin
                if (last_word)                                state_d = ST_HDR_ID;
                else if (sec_q == SEC_W'(CORE_WORDS - 1))     state_d = ST_ROUTE;
            end
            ST_ROUTE: begin
                if (last_word)                                state_d = ST_HDR_ID;
                else if (sec_q == SEC_W'(ROUTE_WORDS - 1))    state_d = ST_INIT;
            end
            ST_INIT: begin
                if (last_word)                                state_d = ST_HDR_ID;
                else if (sec_q == SEC_W'(INIT_WORDS - 1))     state_d = ST_CONTENT;
            end
            ST_CONTENT: begin
                if (last_word)                                state_d = ST_HDR_ID;
            end
            default:                                          state_d = ST_HDR_ID;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HDR_ID;
            match_q <= 1'b0;
            rem_q   <= '0;
            sec_q   <= '0;
            addr_q  <= '0;
        end else if (word_vld) begin
            state_q <= state_d;
            if (state_q == ST_HDR_ID) begin
                match_q <= (word == tile_id);
            end else if (state_q == ST_HDR_LEN) begin
                rem_q  <= word - W'(2);
                sec_q  <= '0;
                addr_q <= '0;
            end else begin
                rem_q <= rem_q - W'(1);
                if (state_d != state_q)         sec_q <= '0;
                else if (state_q != ST_CONTENT) sec_q <= sec_q + SEC_W'(1);
                if (ld_cont)                    addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // output strobes
    always_comb begin
        ld_core   = word_vld && match_q && (state_q == ST_CORE);
        ld_route  = word_vld && match_q && (state_q == ST_ROUTE);
        ld_init   = word_vld && match_q && (state_q == ST_INIT);
        ld_cont   = word_vld && match_q && (state_q == ST_CONTENT);
        pkt_done  = word_vld && match_q &&
                    (last_word || ((state_q == ST_HDR_LEN) && hdr_short));
        cont_addr = addr_q;
    end

    // R4: at most one section loads per word
    p_one_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_core, ld_route, ld_init, ld_cont}));
    // R2: header words never load a section
    p_hdr_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR_ID || state_q == ST_HDR_LEN) |->
            !(ld_core || ld_route || ld_init || ld_cont));
    // R3: an identifier word is always followed by a length word
    p_len_follows_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && state_q == ST_HDR_ID) |=> (state_q == ST_HDR_LEN));
    // R12: idle cycles leave the parser untouched
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(state_q) && $stable(rem_q) && $stable(sec_q)));
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
    parameter int W           = 16,
    parameter int CORE_WORDS  = 3,
    parameter int ROUTE_WORDS = 5,
    parameter int INIT_WORDS  = 1,
    parameter int ADDR_W      = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              word,
    input  logic                      ld_core,
    input  logic                      ld_route,
    input  logic                      ld_init,
    input  logic                      ld_cont,
    input  logic                      pkt_done,
    input  logic [ADDR_W-1:0]         cont_addr,
    output logic [CORE_WORDS*W-1:0]   core_reg,
    output logic [ROUTE_WORDS*W-1:0]  route_reg,
    output logic [INIT_WORDS*W-1:0]   init_reg,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [W-1:0]              wr_data,
    output logic                      loaded
);
    localparam int CORE_BITS  = CORE_WORDS * W;
    localparam int ROUTE_BITS = ROUTE_WORDS * W;
    localparam int INIT_BITS  = INIT_WORDS * W;

    logic [CORE_BITS-1:0]  core_q;
    logic [ROUTE_BITS-1:0] route_q;
    logic [INIT_BITS-1:0]  init_q;
    logic                  wr_en_q;
    logic [ADDR_W-1:0]     wr_addr_q;
    logic [W-1:0]          wr_data_q;
    logic                  loaded_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q    <= '0;
            route_q   <= '0;
            init_q    <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            loaded_q  <= 1'b0;
        end else begin
            if (ld_core)  core_q  <= CORE_BITS'({core_q, word});
            if (ld_route) route_q <= ROUTE_BITS'({route_q, word});
            if (ld_init)  init_q  <= INIT_BITS'({init_q, word});
            wr_en_q <= ld_cont;
            if (ld_cont) begin
                wr_addr_q <= cont_addr;
                wr_data_q <= word;
            end
            if (pkt_done) loaded_q <= 1'b1;
        end
    end

    assign core_reg  = core_q;
    assign route_reg = route_q;
    assign init_reg  = init_q;
    assign wr_en     = wr_en_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign loaded    = loaded_q;

    // R4: core register only moves on a core strobe
    p_core_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_core |=> $stable(core_q));
    // R5: routing register only moves on a route strobe
    p_route_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_route |=> $stable(route_q));
    // R6: start value only moves on an init strobe
    p_init_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_init |=> $stable(init_q));
    // R7: one write pulse per content word
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cont |=> (wr_en && wr_data == $past(word)));
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_cont |=> !wr_en);
    // R9: loaded flag is sticky
    p_loaded_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded);
endmodule

// File: rtl/cfg_tile_loader.sv
module cfg_tile_loader #(
    parameter int W           = 16,
    parameter int CORE_WORDS  = 3,
    parameter int ROUTE_WORDS = 5,
    parameter int INIT_WORDS  = 1,
    parameter int ADDR_W      = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             tile_id,
    input  logic [W-1:0]             cfg_in,
    input  logic                     cfg_in_vld,
    output logic [W-1:0]             cfg_out,
    output logic                     cfg_out_vld,
    output logic [CORE_WORDS*W-1:0]  core_cfg,
    output logic [ROUTE_WORDS*W-1:0] route_cfg,
    output logic [INIT_WORDS*W-1:0]  init_val,
    output logic                     cfg_loaded,
    output logic                     mem_wr_en,
    output logic [ADDR_W-1:0]        mem_wr_addr,
    output logic [W-1:0]             mem_wr_data
);
    logic              ld_core, ld_route, ld_init, ld_cont, pkt_done;
    logic [ADDR_W-1:0] cont_addr;

    cfgld_fwd #(.W(W)) fwd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cfg_in),
        .din_vld  (cfg_in_vld),
        .dout     (cfg_out),
        .dout_vld (cfg_out_vld)
    );

    cfgld_parser #(
        .W(W), .CORE_WORDS(CORE_WORDS), .ROUTE_WORDS(ROUTE_WORDS),
        .INIT_WORDS(INIT_WORDS), .ADDR_W(ADDR_W)
    ) parser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (cfg_in),
        .word_vld  (cfg_in_vld),
        .tile_id   (tile_id),
        .ld_core   (ld_core),
        .ld_route  (ld_route),
        .ld_init   (ld_init),
        .ld_cont   (ld_cont),
        .pkt_done  (pkt_done),
        .cont_addr (cont_addr)
    );

    cfgld_regs #(
        .W(W), .CORE_WORDS(CORE_WORDS), .ROUTE_WORDS(ROUTE_WORDS),
        .INIT_WORDS(INIT_WORDS), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (cfg_in),
        .ld_core   (ld_core),
        .ld_route  (ld_route),
        .ld_init   (ld_init),
        .ld_cont   (ld_cont),
        .pkt_done  (pkt_done),
        .cont_addr (cont_addr),
        .core_reg  (core_cfg),
        .route_reg (route_cfg),
        .init_reg  (init_val),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .loaded    (cfg_loaded)
    );

    // R11: reset leaves outputs quiet
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!cfg_out_vld && !cfg_loaded && !mem_wr_en && core_cfg == '0));
endmodule

// File: tb/cfg_tile_loader_tb.sv
module cfg_tile_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MY_ID = 16'h0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tile_id = MY_ID;
    logic [15:0] cfg_in = '0;
    logic        cfg_in_vld = 1'b0;
    logic [15:0] cfg_out;
    logic        cfg_out_vld;
    logic [47:0] core_cfg;
    logic [79:0] route_cfg;
    logic [15:0] init_val;
    logic        cfg_loaded;
    logic        mem_wr_en;
    logic [9:0]  mem_wr_addr;
    logic [15:0] mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] pkt[$];
    logic [15:0] fwd_q[$];
    logic [25:0] wr_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_tile_loader dut_i (
        .clk(clk), .rst_n(rst_n), .tile_id(tile_id),
        .cfg_in(cfg_in), .cfg_in_vld(cfg_in_vld),
        .cfg_out(cfg_out), .cfg_out_vld(cfg_out_vld),
        .core_cfg(core_cfg), .route_cfg(route_cfg), .init_val(init_val),
        .cfg_loaded(cfg_loaded), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: sends pkt, pushes expected forwarded words and content writes
    task automatic send_pkt(input bit mine, input bit gaps);
        int addr = 0;
        for (int i = 0; i < pkt.size(); i++) begin
            @(negedge clk);
            cfg_in     = pkt[i];
            cfg_in_vld = 1'b1;
            fwd_q.push_back(pkt[i]);
            if (mine && i >= 11) begin
                wr_q.push_back({10'(addr), pkt[i]});
                addr++;
            end
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                cfg_in_vld = 1'b0;
                cfg_in     = 16'hDEAD;
            end
        end
        @(negedge clk);
        cfg_in_vld = 1'b0;
    endtask

    // monitor: forwarded words (R1) and content writes (R7)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cfg_out_vld) begin
                if (fwd_q.size() == 0) chk(0, "R1 unexpected forward", 80'(cfg_out), 80'h0);
                else begin
                    logic [15:0] e;
                    e = fwd_q.pop_front();
                    chk(cfg_out == e, "R1 forwarded word", 80'(cfg_out), 80'(e));
                end
            end
            if (mem_wr_en) begin
                if (wr_q.size() == 0) chk(0, "R7 unexpected write", 80'({mem_wr_addr, mem_wr_data}), 80'h0);
                else begin
                    logic [25:0] e;
                    e = wr_q.pop_front();
                    chk({mem_wr_addr, mem_wr_data} == e, "R7 content write",
                        80'({mem_wr_addr, mem_wr_data}), 80'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 80'h0, 80'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(core_cfg == '0 && route_cfg == '0 && init_val == '0, "R11 regs zero",
            80'(core_cfg), 80'h0);
        chk(!cfg_loaded && !cfg_out_vld && !mem_wr_en, "R11 flags low",
            80'({cfg_loaded, cfg_out_vld, mem_wr_en}), 80'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: foreign packet with a fake header inside its payload
        pkt = '{16'h0007, 16'd12, MY_ID, 16'h0002, 16'hA001, 16'hA002,
                16'hA003, 16'hA004, 16'hA005, 16'hA006, 16'hA007, 16'hA008};
        send_pkt(0, 0);
        chk(!cfg_loaded, "R8 foreign packet no load flag", 80'(cfg_loaded), 80'h0);
        chk(core_cfg == '0 && route_cfg == '0 && init_val == '0, "R2 foreign packet no regs",
            80'(core_cfg), 80'h0);

        // matching packet with idle gaps (R4 R5 R6 R7 R9 R12)
        pkt = '{MY_ID, 16'd15, 16'h1111, 16'h2222, 16'h3333,
                16'h4001, 16'h4002, 16'h4003, 16'h4004, 16'h4005,
                16'h5A5A, 16'hC000, 16'hC001, 16'hC002, 16'hC003};
        send_pkt(1, 1);
        chk(cfg_loaded, "R9 loaded after final word", 80'(cfg_loaded), 80'h1);
        chk(core_cfg == 48'h1111_2222_3333, "R4 core msb first", 80'(core_cfg), 80'h1111_2222_3333);
        chk(route_cfg == 80'h4001_4002_4003_4004_4005, "R5 route", route_cfg,
            80'h4001_4002_4003_4004_4005);
        chk(init_val == 16'h5A5A, "R6 init value", 80'(init_val), 80'h5A5A);
        chk(wr_q.size() == 0, "R7 all writes seen (R12 gaps)", 80'(wr_q.size()), 80'h0);

        // R10: short matching packet, two core words only
        pkt = '{MY_ID, 16'd4, 16'hAAAA, 16'hBBBB};
        send_pkt(1, 0);
        @(negedge clk);
        chk(core_cfg == 48'h3333_AAAA_BBBB, "R10 partial core shift", 80'(core_cfg), 80'h3333_AAAA_BBBB);
        chk(route_cfg == 80'h4001_4002_4003_4004_4005, "R10 route kept", route_cfg,
            80'h4001_4002_4003_4004_4005);
        chk(init_val == 16'h5A5A, "R10 init kept", 80'(init_val), 80'h5A5A);
        chk(cfg_loaded, "R9 loaded sticky", 80'(cfg_loaded), 80'h1);

        // R3: foreign packet of length 1, then matching packet without content
        pkt = '{16'h0009, 16'd1};
        send_pkt(0, 0);
        pkt = '{MY_ID, 16'd11, 16'h0102, 16'h0304, 16'h0506,
                16'h0007, 16'h0008, 16'h0009, 16'h000A, 16'h000B, 16'hBEEF};
        send_pkt(1, 0);
        @(negedge clk);
        chk(core_cfg == 48'h0102_0304_0506, "R3 short length resync core", 80'(core_cfg),
            80'h0102_0304_0506);
        chk(route_cfg == 80'h0007_0008_0009_000A_000B, "R5 route reload", route_cfg,
            80'h0007_0008_0009_000A_000B);
        chk(init_val == 16'hBEEF, "R6 init reload", 80'(init_val), 80'hBEEF);

        // R2: header-only matching packet (length 0) changes no register
        pkt = '{MY_ID, 16'd0};
        send_pkt(1, 0);
        repeat (2) @(negedge clk);
        chk(core_cfg == 48'h0102_0304_0506 && init_val == 16'hBEEF, "R3 header-only no change",
            80'(core_cfg), 80'h0102_0304_0506);
        chk(fwd_q.size() == 0 && wr_q.size() == 0, "R1 queues drained",
            80'(fwd_q.size()), 80'h0);
        finish_run();
    end
endmodule